// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block holds the interrupt status flags of a storage-card host controller. Single-cycle event pulses from the command engine, data engine, DMA engine and card-detect logic enter one side. Each event is gated by a per-bit status-enable mask before it can latch. A second per-bit signal-enable mask selects which latched flags drive the single interrupt line. Software clears flags with write-one-to-clear strobes.

Software can also inject error and card-interrupt events through a force strobe. A six-flag sub-register records why the automatic stop command failed, and any of those flags raises one summary bit in the main status vector. Grouped command and data error summaries are exported. Insertion and removal of a card each have their own wake-up enable.

All pins are plain control and status levels or strobes. There is no streamed data, so there is no valid/ready handshake and no back-pressure.

Top module: `irq_stat_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released with no stimulus, `status_o`, `as_flags_o`, `irq_o`, `wake_o`, `cmd_err_o` and `dat_err_o` are all zero.
- R2: An event on status bit k sets `status_o[k]` at the next clock edge only if `stat_en_i[k]` is 1. With the enable at 0 the bit stays 0.
- R3: When `clr_we_i` is high, each 1 in `clr_i` clears the matching status bit at the next edge. Each 0 in `clr_i` leaves its bit unchanged.
- R4: If an enabled event and a clear hit the same bit in the same cycle, the bit is 1 after the edge.
- R5: `irq_o` is registered. After each edge it equals the OR over all bits of (`status_o` AND `sig_en_i`), taken from the cycle before that edge. `sig_en_i` never alters `status_o`.
- R6: `cmd_err_o` is the OR of status bits 9 to 12 (command timeout 9, command CRC 10, command end-bit 11, command index 12). `dat_err_o` is the OR of bits 13 to 15 (data timeout 13, data CRC 14, data end-bit 15). The other bit positions are: 0 command done, 1 transfer done, 2 block gap, 3 DMA done, 4 write buffer ready, 5 read buffer ready, 6 card inserted, 7 card removed, 8 card interrupt, 16 auto-stop error summary, 17 DMA error.
- R7: Pulses on `as_evt_i` latch into `as_flags_o`. The flags are bit 0 not executed, 1 timeout, 2 end-bit, 3 CRC, 4 index, 5 command not issued. Any such pulse, or an event on `evt_i[16]`, sets status bit 16. All of this is gated by `stat_en_i[16]`. Clearing bit 16 also clears every sub-flag that is not being set in the same cycle.
- R8: When `force_we_i` is high, 1s in `force_i[17:8]` and in `force_as_i` act exactly like the matching real events. 1s in `force_i[7:0]` have no effect.
- R9: Card insertion (bit 6) and card removal (bit 7) are separate status bits. The registered `wake_o` equals (bit 6 AND `wake_en_i[0]`) OR (bit 7 AND `wake_en_i[1]`), taken from the cycle before the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 18 | Event pulses, one per status bit |
| as_evt_i | input | 6 | Auto-stop failure cause pulses |
| stat_en_i | input | 18 | Status-enable mask |
| sig_en_i | input | 18 | Signal-enable mask for the interrupt line |
| wake_en_i | input | 2 | Wake enables: [0] insertion, [1] removal |
| clr_we_i | input | 1 | Clear strobe |
| clr_i | input | 18 | Write-one-to-clear pattern |
| force_we_i | input | 1 | Force strobe |
| force_i | input | 18 | Force pattern; only bits 17:8 act |
| force_as_i | input | 6 | Force pattern for auto-stop causes |
| status_o | output | 18 | Latched status flags |
| as_flags_o | output | 6 | Auto-stop cause flags |
| irq_o | output | 1 | Registered interrupt line |
| wake_o | output | 1 | Registered card-detect wake request |
| cmd_err_o | output | 1 | Command error group summary |
| dat_err_o | output | 1 | Data error group summary |

## Verification
An event from the sources, or from the force path, can land in the same cycle as a software clear of the same bit. That collision is the interesting case. A directed case puts an enabled event and a clear on one bit together. The bench also checks that a clear of the auto-stop summary keeps any sub-flag that arrives in that cycle. Long random runs draw dense clear patterns alongside sparse events so that the overlap happens often. Every cycle, all outputs are compared with a bench model in which the set term takes priority over the clear term.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int NSTAT = 18;
  localparam int AS_W  = 6;

  localparam int B_CMD_DONE = 0;
  localparam int B_XFER_DONE = 1;
  localparam int B_GAP = 2;
  localparam int B_DMA_DONE = 3;
  localparam int B_WR_RDY = 4;
  localparam int B_RD_RDY = 5;
  localparam int B_CARD_IN = 6;
  localparam int B_CARD_OUT = 7;
  localparam int B_CARD_IRQ = 8;
  localparam int B_CMD_TMO = 9;
  localparam int B_CMD_CRC = 10;
  localparam int B_CMD_END = 11;
  localparam int B_CMD_IDX = 12;
  localparam int B_DAT_TMO = 13;
  localparam int B_DAT_CRC = 14;
  localparam int B_DAT_END = 15;
  localparam int B_AS_ERR = 16;
  localparam int B_DMA_ERR = 17;

  localparam logic [NSTAT-1:0] CMD_ERR_MASK = 18'h01E00;
  localparam logic [NSTAT-1:0] DAT_ERR_MASK = 18'h0E000;
  localparam logic [NSTAT-1:0] FORCE_MASK   = 18'h3FF00;
endpackage

// File: rtl/irq_stat_bit.sv
module irq_stat_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;   // set beats clear
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/irq_autostop.sv
module irq_autostop #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] evt_i,
  input  logic         frc_we_i,
  input  logic [W-1:0] frc_i,
  input  logic         clr_i,
  output logic [W-1:0] flags_o,
  output logic         hit_o
);
  logic [W-1:0] set_v;

  always_comb begin
    set_v = (evt_i | (frc_we_i ? frc_i : '0)) & {W{en_i}};
    hit_o = |set_v;
  end

  for (genvar g = 0; g < W; g++) begin : g_flag
    irq_stat_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_v[g]),
      .clr_i (clr_i),
      .q_o   (flags_o[g])
    );
  end
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int N = 18,
  parameter logic [N-1:0] CMD_MASK = '0,
  parameter logic [N-1:0] DAT_MASK = '0,
  parameter int IN_POS = 6,
  parameter int OUT_POS = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] status_i,
  input  logic [N-1:0] sig_en_i,
  input  logic [1:0]   wake_en_i,
  output logic         irq_o,
  output logic         wake_o,
  output logic         cmd_err_o,
  output logic         dat_err_o
);
  logic irq_d, wake_d;

  always_comb begin
    irq_d     = |(status_i & sig_en_i);
    wake_d    = (status_i[IN_POS] & wake_en_i[0]) | (status_i[OUT_POS] & wake_en_i[1]);
    cmd_err_o = |(status_i & CMD_MASK);
    dat_err_o = |(status_i & DAT_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o  <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      irq_o  <= irq_d;
      wake_o <= wake_d;
    end
  end
endmodule

// File: rtl/irq_stat_ctrl.sv
module irq_stat_ctrl
  import irq_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSTAT-1:0] evt_i,
  input  logic [AS_W-1:0]  as_evt_i,
  input  logic [NSTAT-1:0] stat_en_i,
  input  logic [NSTAT-1:0] sig_en_i,
  input  logic [1:0]       wake_en_i,
  input  logic             clr_we_i,
  input  logic [NSTAT-1:0] clr_i,
  input  logic             force_we_i,
  input  logic [NSTAT-1:0] force_i,
  input  logic [AS_W-1:0]  force_as_i,
  output logic [NSTAT-1:0] status_o,
  output logic [AS_W-1:0]  as_flags_o,
  output logic             irq_o,
  output logic             wake_o,
  output logic             cmd_err_o,
  output logic             dat_err_o
);
  logic [NSTAT-1:0] raw_v, set_v, clr_v;
  logic             as_hit;

  irq_autostop #(.W(AS_W)) u_as (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (stat_en_i[B_AS_ERR]),
    .evt_i    (as_evt_i),
    .frc_we_i (force_we_i),
    .frc_i    (force_as_i),
    .clr_i    (clr_v[B_AS_ERR]),
    .flags_o  (as_flags_o),
    .hit_o    (as_hit)
  );

  always_comb begin
    raw_v = evt_i | (force_we_i ? (force_i & FORCE_MASK) : '0);
    raw_v[B_AS_ERR] = raw_v[B_AS_ERR] | as_hit;
    set_v = raw_v & stat_en_i;
    clr_v = clr_we_i ? clr_i : '0;
  end

  for (genvar g = 0; g < NSTAT; g++) begin : g_stat
    irq_stat_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_v[g]),
      .clr_i (clr_v[g]),
      .q_o   (status_o[g])
    );
  end

  irq_out_stage #(
    .N        (NSTAT),
    .CMD_MASK (CMD_ERR_MASK),
    .DAT_MASK (DAT_ERR_MASK),
    .IN_POS   (B_CARD_IN),
    .OUT_POS  (B_CARD_OUT)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .status_i  (status_o),
    .sig_en_i  (sig_en_i),
    .wake_en_i (wake_en_i),
    .irq_o     (irq_o),
    .wake_o    (wake_o),
    .cmd_err_o (cmd_err_o),
    .dat_err_o (dat_err_o)
  );
endmodule

// File: rtl/irq_stat_chk.sv
module irq_stat_chk
  import irq_stat_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [NSTAT-1:0] evt_i,
  input logic [NSTAT-1:0] stat_en_i,
  input logic [NSTAT-1:0] sig_en_i,
  input logic [1:0]       wake_en_i,
  input logic             clr_we_i,
  input logic [NSTAT-1:0] clr_i,
  input logic             force_we_i,
  input logic [NSTAT-1:0] status_o,
  input logic [AS_W-1:0]  as_flags_o,
  input logic             irq_o,
  input logic             wake_o
);
  localparam logic [NSTAT-1:0] AS_BIT = NSTAT'(1) << B_AS_ERR;

  // R2
  masked_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o & ~$past(status_o) & ~$past(stat_en_i)) == '0));

  // R4
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i & stat_en_i) != '0) |=>
      ((status_o & $past(evt_i & stat_en_i)) == $past(evt_i & stat_en_i)));

  // R3
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && !force_we_i) |=>
      ((status_o & $past(clr_i & ~evt_i & ~AS_BIT)) == '0));

  // R5
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(status_o & sig_en_i))));

  // R7
  as_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (as_flags_o != '0) |-> status_o[B_AS_ERR]);

  // R9
  wake_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (wake_o == $past((status_o[B_CARD_IN] & wake_en_i[0]) |
                              (status_o[B_CARD_OUT] & wake_en_i[1]))));
endmodule

bind irq_stat_ctrl irq_stat_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_i      (evt_i),
  .stat_en_i  (stat_en_i),
  .sig_en_i   (sig_en_i),
  .wake_en_i  (wake_en_i),
  .clr_we_i   (clr_we_i),
  .clr_i      (clr_i),
  .force_we_i (force_we_i),
  .status_o   (status_o),
  .as_flags_o (as_flags_o),
  .irq_o      (irq_o),
  .wake_o     (wake_o)
);

// File: tb/irq_stat_ctrl_tb.sv
module irq_stat_ctrl_tb;
  localparam int N = 18;
  localparam int A = 6;
  localparam logic [N-1:0] FMASK = 18'h3FF00;
  localparam logic [N-1:0] CMASK = 18'h01E00;
  localparam logic [N-1:0] DMASK = 18'h0E000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] evt_i = '0, stat_en_i = '0, sig_en_i = '0, clr_i = '0, force_i = '0;
  logic [A-1:0] as_evt_i = '0, force_as_i = '0;
  logic [1:0] wake_en_i = '0;
  logic clr_we_i = 1'b0, force_we_i = 1'b0;
  logic [N-1:0] status_o;
  logic [A-1:0] as_flags_o;
  logic irq_o, wake_o, cmd_err_o, dat_err_o;

  int total = 0;
  int bad = 0;
  logic [N-1:0] m_stat = '0;
  logic [A-1:0] m_as = '0;
  logic m_irq = 1'b0, m_wake = 1'b0;

  always #10 clk = ~clk;

  irq_stat_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .as_evt_i(as_evt_i),
    .stat_en_i(stat_en_i), .sig_en_i(sig_en_i), .wake_en_i(wake_en_i),
    .clr_we_i(clr_we_i), .clr_i(clr_i), .force_we_i(force_we_i),
    .force_i(force_i), .force_as_i(force_as_i), .status_o(status_o),
    .as_flags_o(as_flags_o), .irq_o(irq_o), .wake_o(wake_o),
    .cmd_err_o(cmd_err_o), .dat_err_o(dat_err_o)
  );

  function automatic logic [N-1:0] next_set();
    logic [N-1:0] s;
    logic [A-1:0] a;
    a = as_evt_i | (force_we_i ? force_as_i : '0);
    s = evt_i | (force_we_i ? (force_i & FMASK) : '0);
    s[16] = s[16] | (|a);
    return s & stat_en_i;
  endfunction

  function automatic logic [A-1:0] next_as_set();
    return (as_evt_i | (force_we_i ? force_as_i : '0)) & {A{stat_en_i[16]}};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "status", 32'(status_o), 32'(m_stat));
    chk(tag, "as_flags R7", 32'(as_flags_o), 32'(m_as));
    chk(tag, "irq R5", 32'(irq_o), 32'(m_irq));
    chk(tag, "wake R9", 32'(wake_o), 32'(m_wake));
    chk(tag, "cmd_err R6", 32'(cmd_err_o), 32'(|(m_stat & CMASK)));
    chk(tag, "dat_err R6", 32'(dat_err_o), 32'(|(m_stat & DMASK)));
  endtask

  // inputs already driven (after a negedge); advance one edge, update model, check
  task automatic step(input string tag);
    logic [N-1:0] s, c;
    logic [A-1:0] a;
    s = next_set();
    a = next_as_set();
    c = clr_we_i ? clr_i : '0;
    m_irq  = |(m_stat & sig_en_i);
    m_wake = (m_stat[6] & wake_en_i[0]) | (m_stat[7] & wake_en_i[1]);
    m_as   = c[16] ? a : (m_as | a);
    m_stat = (m_stat & ~c) | s;
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic idle();
    evt_i = '0; as_evt_i = '0; clr_we_i = 1'b0; clr_i = '0;
    force_we_i = 1'b0; force_i = '0; force_as_i = '0;
  endtask

  initial begin
    #3_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after release");

    // R2: masked event does not latch
    sig_en_i = '1;
    stat_en_i = 18'h3FFFE; evt_i = 18'h00001;
    step("R2 masked");
    idle(); step("R2 masked idle");
    // R2: enabled event latches; then irq follows (R5)
    stat_en_i = '1; evt_i = 18'h00202;
    step("R2 enabled");
    idle(); step("R5 irq follows");
    // R3: zeros in clr leave bits; ones clear
    clr_we_i = 1'b1; clr_i = 18'h00002;
    step("R3 w1c");
    idle(); step("R3 idle");
    // R4: event and clear on same bit
    evt_i = 18'h00400; clr_we_i = 1'b1; clr_i = 18'h00600;
    step("R4 collide");
    idle();
    // R8: force of low bits ignored, high bits act
    force_we_i = 1'b1; force_i = 18'h000FF;
    step("R8 force low ignored");
    force_we_i = 1'b1; force_i = 18'h28100;
    step("R8 force high");
    // R7: sub-flags, and clear of summary with a new sub-flag
    idle(); as_evt_i = 6'b000101;
    step("R7 subflags");
    idle(); force_we_i = 1'b1; force_as_i = 6'b100000;
    step("R8 force subflag");
    idle(); clr_we_i = 1'b1; clr_i = 18'h10000; as_evt_i = 6'b001000;
    step("R7 clear with new subflag");
    idle(); clr_we_i = 1'b1; clr_i = 18'h10000;
    step("R7 clear summary");
    // R9: insertion/removal wake
    idle(); evt_i = 18'h00040; wake_en_i = 2'b10;
    step("R9 insert no wake");
    idle(); step("R9 insert no wake idle");
    wake_en_i = 2'b01; step("R9 insert wake");
    idle(); evt_i = 18'h00080; clr_we_i = 1'b1; clr_i = 18'h00040; wake_en_i = 2'b10;
    step("R9 removal separate");
    idle(); step("R9 removal wake");
    // R5: sig_en gates irq but not status
    clr_we_i = 1'b1; clr_i = '1; step("R3 clear all");
    idle(); sig_en_i = '0; evt_i = 18'h00008; step("R5 sig off");
    idle(); step("R5 sig off idle");

    // random collisions
    for (int i = 0; i < 3000; i++) begin
      evt_i      = N'($urandom & $urandom & $urandom);
      as_evt_i   = A'($urandom & $urandom & $urandom);
      stat_en_i  = N'($urandom | $urandom);
      sig_en_i   = N'($urandom);
      wake_en_i  = 2'($urandom);
      clr_we_i   = ($urandom % 3) != 0;
      clr_i      = N'($urandom | $urandom);
      force_we_i = ($urandom % 5) == 0;
      force_i    = N'($urandom);
      force_as_i = A'($urandom & $urandom);
      step("R4 random");
    end
    idle();
    step("R4 random tail");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule